// File: doc/BRIEF.md
# Pipeline Squash Request Encoder

This block turns a single flush request raised by the execute stage into the squash record that goes to the commit stage. Three causes can raise a request: a mispredicted branch, a memory ordering violation and a load that could not proceed because memory was blocked. The cause decides where fetch restarts and whether the offending instruction is itself re-executed.

The execute stage presents a cause code together with the offending instruction's sequence number, its PC, its next PC and its next-next PC. One cycle later the block presents a registered record: a valid pulse, the sequence number, the restart PC pair, the mispredict PC, a mispredict flag, a taken flag and an include-self flag. A blocked-load request also raises an acknowledge pulse toward the load/store unit in the same cycle as the record.

The taken flag is derived from PC arithmetic. A parameter selects whether the instruction set has branch delay slots, which changes the taken rule. Choosing the oldest of several competing requests is left to the requester: the block accepts at most one request per cycle.

Top module: `squash_encoder`

## Requirements
- R1: While rst_ni is low and in the first cycle after it, every output is 0.
- R2: A request (cause_i not 2'b00) sampled at a rising edge yields sq_valid_o high for exactly the following cycle. With cause_i = 2'b00, the next cycle has sq_valid_o low and every other output 0. Back-to-back requests give back-to-back records.
- R3: Cause 2'b01 (branch mispredict) gives mispred_o = 1, mispred_pc_o = pc_i, redir_pc_o = npc_i and redir_npc_o = nnpc_i.
- R4: With DELAY_SLOT = 0, a branch record has taken_o = 1 exactly when npc_i != pc_i + INSN_BYTES (INSN_BYTES = 4 by default).
- R5: With DELAY_SLOT = 1, a branch record has taken_o = 0 exactly when nnpc_i == npc_i + INSN_BYTES and npc_i equals pc_i + INSN_BYTES or pc_i + 2*INSN_BYTES. Otherwise taken_o = 1.
- R6: Cause 2'b10 (memory ordering violation) gives mispred_o = 0, mispred_pc_o = 0, taken_o = 0, redir_pc_o = npc_i and redir_npc_o = nnpc_i.
- R7: Cause 2'b11 (blocked load) gives mispred_o = 0, mispred_pc_o = 0, taken_o = 0, redir_pc_o = pc_i and redir_npc_o = npc_i.
- R8: incl_self_o is 1 only in a blocked-load record. It is 0 for the other two causes.
- R9: ld_ack_o pulses for one cycle, in the same cycle as the record, only for a blocked-load request.
- R10: Every record carries sq_seq_o equal to the seq_i sampled with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cause_i | input | 2 | Request cause: 00 none, 01 branch, 10 ordering, 11 blocked load |
| seq_i | input | SEQ_W | Sequence number of the offending instruction |
| pc_i | input | PC_W | PC of the offending instruction |
| npc_i | input | PC_W | Next PC of the offending instruction |
| nnpc_i | input | PC_W | Next-next PC of the offending instruction |
| sq_valid_o | output | 1 | Squash record valid |
| sq_seq_o | output | SEQ_W | Squashed sequence number |
| redir_pc_o | output | PC_W | Restart PC |
| redir_npc_o | output | PC_W | Restart next PC |
| mispred_pc_o | output | PC_W | PC of the mispredicted branch |
| mispred_o | output | 1 | Branch mispredict flag |
| taken_o | output | 1 | Branch was taken |
| incl_self_o | output | 1 | Offending instruction is squashed too |
| ld_ack_o | output | 1 | Blocked-load handled acknowledge |

## Verification
Every result is due exactly one rising edge after the request is sampled, and nothing is due later. The bench changes inputs on the falling edge and checks all record fields on the next falling edge, half a period after the edge that registers them. The check is against a model of the request that was just driven. Two instances, one without delay slots and one with, take the same stimulus, so both taken rules are checked on identical PC triples. The idle cycles between requests check that the record drops after one cycle.

// File: rtl/squash_pkg.sv
package squash_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_BRANCH = 2'b01,
    CAUSE_ORDER  = 2'b10,
    CAUSE_LDBLK  = 2'b11
  } cause_e;
endpackage

// File: rtl/squash_taken_calc.sv
module squash_taken_calc #(
  parameter int unsigned PC_W       = 32,
  parameter int unsigned INSN_BYTES = 4,
  parameter bit          DELAY_SLOT = 1'b0
) (
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] npc_i,
  input  logic [PC_W-1:0] nnpc_i,
  output logic            taken_o
);
  localparam logic [PC_W-1:0] STEP  = PC_W'(INSN_BYTES);
  localparam logic [PC_W-1:0] STEP2 = PC_W'(2 * INSN_BYTES);

  generate
    if (DELAY_SLOT) begin : g_ds
      logic seq_nn, seq_n;
      always_comb begin
        seq_nn  = (nnpc_i == npc_i + STEP);
        seq_n   = (npc_i == pc_i + STEP) || (npc_i == pc_i + STEP2);
        taken_o = !(seq_nn && seq_n);
      end
    end else begin : g_nods
      logic unused_nnpc;
      always_comb begin
        taken_o     = (npc_i != pc_i + STEP);
        unused_nnpc = ^nnpc_i;
      end
    end
  endgenerate
endmodule

// File: rtl/squash_record_build.sv
module squash_record_build #(
  parameter int unsigned PC_W       = 32,
  parameter int unsigned INSN_BYTES = 4,
  parameter bit          DELAY_SLOT = 1'b0
) (
  input  squash_pkg::cause_e cause_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [PC_W-1:0]    npc_i,
  input  logic [PC_W-1:0]    nnpc_i,
  output logic               valid_o,
  output logic [PC_W-1:0]    redir_pc_o,
  output logic [PC_W-1:0]    redir_npc_o,
  output logic [PC_W-1:0]    mispred_pc_o,
  output logic               mispred_o,
  output logic               taken_o,
  output logic               incl_self_o,
  output logic               ld_ack_o
);
  import squash_pkg::*;

  logic br_taken;

  squash_taken_calc #(
    .PC_W(PC_W), .INSN_BYTES(INSN_BYTES), .DELAY_SLOT(DELAY_SLOT)
  ) u_taken (
    .pc_i(pc_i), .npc_i(npc_i), .nnpc_i(nnpc_i), .taken_o(br_taken)
  );

  always_comb begin
    valid_o      = 1'b0;
    redir_pc_o   = '0;
    redir_npc_o  = '0;
    mispred_pc_o = '0;
    mispred_o    = 1'b0;
    taken_o      = 1'b0;
    incl_self_o  = 1'b0;
    ld_ack_o     = 1'b0;
    unique case (cause_i)
      CAUSE_BRANCH: begin
        valid_o      = 1'b1;
        redir_pc_o   = npc_i;
        redir_npc_o  = nnpc_i;
        mispred_pc_o = pc_i;
        mispred_o    = 1'b1;
        taken_o      = br_taken;
      end
      CAUSE_ORDER: begin
        valid_o     = 1'b1;
        redir_pc_o  = npc_i;
        redir_npc_o = nnpc_i;
      end
      CAUSE_LDBLK: begin
        // replay the load itself
        valid_o     = 1'b1;
        redir_pc_o  = pc_i;
        redir_npc_o = npc_i;
        incl_self_o = 1'b1;
        ld_ack_o    = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/squash_encoder.sv
module squash_encoder #(
  parameter int unsigned PC_W       = 32,
  parameter int unsigned SEQ_W      = 16,
  parameter int unsigned INSN_BYTES = 4,
  parameter bit          DELAY_SLOT = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       cause_i,
  input  logic [SEQ_W-1:0] seq_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PC_W-1:0]  npc_i,
  input  logic [PC_W-1:0]  nnpc_i,
  output logic             sq_valid_o,
  output logic [SEQ_W-1:0] sq_seq_o,
  output logic [PC_W-1:0]  redir_pc_o,
  output logic [PC_W-1:0]  redir_npc_o,
  output logic [PC_W-1:0]  mispred_pc_o,
  output logic             mispred_o,
  output logic             taken_o,
  output logic             incl_self_o,
  output logic             ld_ack_o
);
  import squash_pkg::*;

  cause_e            cause;
  logic              n_valid, n_mispred, n_taken, n_incl, n_ack;
  logic [PC_W-1:0]   n_rpc, n_rnpc, n_mpc;

  assign cause = cause_e'(cause_i);

  squash_record_build #(
    .PC_W(PC_W), .INSN_BYTES(INSN_BYTES), .DELAY_SLOT(DELAY_SLOT)
  ) u_build (
    .cause_i(cause), .pc_i(pc_i), .npc_i(npc_i), .nnpc_i(nnpc_i),
    .valid_o(n_valid), .redir_pc_o(n_rpc), .redir_npc_o(n_rnpc),
    .mispred_pc_o(n_mpc), .mispred_o(n_mispred), .taken_o(n_taken),
    .incl_self_o(n_incl), .ld_ack_o(n_ack)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_valid_o   <= 1'b0;
      sq_seq_o     <= '0;
      redir_pc_o   <= '0;
      redir_npc_o  <= '0;
      mispred_pc_o <= '0;
      mispred_o    <= 1'b0;
      taken_o      <= 1'b0;
      incl_self_o  <= 1'b0;
      ld_ack_o     <= 1'b0;
    end else begin
      sq_valid_o   <= n_valid;
      sq_seq_o     <= n_valid ? seq_i : '0;
      redir_pc_o   <= n_rpc;
      redir_npc_o  <= n_rnpc;
      mispred_pc_o <= n_mpc;
      mispred_o    <= n_mispred;
      taken_o      <= n_taken;
      incl_self_o  <= n_incl;
      ld_ack_o     <= n_ack;
    end
  end

  AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_i != 2'b00) |=> sq_valid_o); // R2
  AST_IDLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_i == 2'b00) |=> (!sq_valid_o && !ld_ack_o && !incl_self_o && !mispred_o)); // R2
  AST_MISPRED_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_i == 2'b01) |=> (mispred_o && mispred_pc_o == $past(pc_i))); // R3
  AST_INCL_ONLY_LDBLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_i != 2'b11) |=> !incl_self_o); // R8
  AST_ACK_ONLY_LDBLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ack_o |-> (sq_valid_o && incl_self_o && !mispred_o)); // R9
  AST_SEQ_CARRIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_i != 2'b00) |=> (sq_seq_o == $past(seq_i))); // R10
endmodule

// File: tb/tb_squash_encoder.sv
`timescale 1ns/1ps
module tb_squash_encoder;
  localparam int PC_W = 32, SEQ_W = 16, IB = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cause = 2'b00;
  logic [SEQ_W-1:0] seq = '0;
  logic [PC_W-1:0] pc = '0, npc = '0, nnpc = '0;

  logic v0, m0, t0, i0, a0, v1, m1, t1, i1, a1;
  logic [SEQ_W-1:0] s0, s1;
  logic [PC_W-1:0] rp0, rn0, mp0, rp1, rn1, mp1;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  squash_encoder #(.DELAY_SLOT(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cause_i(cause), .seq_i(seq), .pc_i(pc),
    .npc_i(npc), .nnpc_i(nnpc), .sq_valid_o(v0), .sq_seq_o(s0),
    .redir_pc_o(rp0), .redir_npc_o(rn0), .mispred_pc_o(mp0), .mispred_o(m0),
    .taken_o(t0), .incl_self_o(i0), .ld_ack_o(a0));

  squash_encoder #(.DELAY_SLOT(1'b1)) dut_ds (
    .clk_i(clk), .rst_ni(rst_n), .cause_i(cause), .seq_i(seq), .pc_i(pc),
    .npc_i(npc), .nnpc_i(nnpc), .sq_valid_o(v1), .sq_seq_o(s1),
    .redir_pc_o(rp1), .redir_npc_o(rn1), .mispred_pc_o(mp1), .mispred_o(m1),
    .taken_o(t1), .incl_self_o(i1), .ld_ack_o(a1));

  function automatic logic exp_taken(bit ds, logic [PC_W-1:0] p, n, nn);
    if (!ds) return n != p + IB;
    return !((nn == n + IB) && ((n == p + IB) || (n == p + 2 * IB)));
  endfunction

  task automatic chk(string req, string what, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive on falling edge, check on the next falling edge
  task automatic req(logic [1:0] c, logic [SEQ_W-1:0] sq,
                     logic [PC_W-1:0] p, n, nn);
    logic [PC_W-1:0] erp, ern, emp;
    logic ev, em, ei, ea;
    cause = c; seq = sq; pc = p; npc = n; nnpc = nn;
    @(negedge clk);
    ev = (c != 2'b00);
    em = (c == 2'b01);
    ei = (c == 2'b11);
    ea = ei;
    emp = em ? p : '0;
    erp = (c == 2'b11) ? p : (ev ? n : '0);
    ern = (c == 2'b11) ? n : (ev ? nn : '0);
    chk("R2", "valid", PC_W'(v0), PC_W'(ev));
    chk("R2", "valid_ds", PC_W'(v1), PC_W'(ev));
    chk("R10", "seq", PC_W'(s0), ev ? PC_W'(sq) : '0);
    chk(c == 2'b11 ? "R7" : (c == 2'b10 ? "R6" : "R3"), "redir_pc", rp0, erp);
    chk(c == 2'b11 ? "R7" : (c == 2'b10 ? "R6" : "R3"), "redir_npc", rn0, ern);
    chk(c == 2'b11 ? "R7" : (c == 2'b10 ? "R6" : "R3"), "redir_pc_ds", rp1, erp);
    chk(c == 2'b11 ? "R7" : (c == 2'b10 ? "R6" : "R3"), "redir_npc_ds", rn1, ern);
    chk("R3", "mispred_pc", mp0, emp);
    chk("R3", "mispred", PC_W'(m0), PC_W'(em));
    chk("R3", "mispred_ds", PC_W'(m1), PC_W'(em));
    chk("R4", "taken", PC_W'(t0), PC_W'(em && exp_taken(0, p, n, nn)));
    chk("R5", "taken_ds", PC_W'(t1), PC_W'(em && exp_taken(1, p, n, nn)));
    chk("R8", "incl_self", PC_W'(i0), PC_W'(ei));
    chk("R8", "incl_self_ds", PC_W'(i1), PC_W'(ei));
    chk("R9", "ld_ack", PC_W'(a0), PC_W'(ea));
    chk("R9", "ld_ack_ds", PC_W'(a1), PC_W'(ea));
  endtask

  initial begin
    process_seed: begin
      int unsigned s;
      s = $urandom(32'h5a17);
    end
    cause = 2'b11; pc = 32'h100; npc = 32'h104;
    #3;
    // R1: in reset
    chk("R1", "valid_in_reset", PC_W'(v0), '0);
    chk("R1", "ack_in_reset", PC_W'(a0), '0);
    chk("R1", "redir_in_reset", rp0, '0);
    @(negedge clk);
    cause = 2'b00;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "valid_after_reset", PC_W'(v0), '0);
    chk("R1", "mispred_pc_after_reset", mp0, '0);

    // directed: R4/R5 corner PC triples
    req(2'b01, 16'h0011, 32'h1000, 32'h1004, 32'h1008); // not taken both
    req(2'b01, 16'h0012, 32'h1000, 32'h1008, 32'h100c); // taken nods, not ds
    req(2'b01, 16'h0013, 32'h1000, 32'h1004, 32'h2000); // ds taken only
    req(2'b01, 16'h0014, 32'h1000, 32'h100c, 32'h1010); // taken both
    req(2'b00, 16'h0015, 32'h1000, 32'h1004, 32'h1008); // idle
    // R6, R7, R8, R9 back to back
    req(2'b10, 16'h0021, 32'h2000, 32'h2004, 32'h2008);
    req(2'b11, 16'h0022, 32'h3000, 32'h3004, 32'h3008);
    req(2'b11, 16'hffff, 32'hfffffffc, 32'h0, 32'h4);
    req(2'b00, 16'h0000, 32'h0, 32'h0, 32'h0);
    req(2'b01, 16'h0031, 32'hfffffff8, 32'hfffffffc, 32'h0); // wrap, not taken

    for (int k = 0; k < 400; k++) begin
      logic [PC_W-1:0] p, n, nn;
      logic [1:0] c;
      p = {$urandom(), 2'b00} & 32'hfffffffc;
      case ($urandom_range(0, 3))
        0: n = p + 4;
        1: n = p + 8;
        2: n = p + 12;
        default: n = {$urandom(), 2'b00};
      endcase
      nn = ($urandom_range(0, 2) != 0) ? n + 4 : {$urandom(), 2'b00};
      c = 2'($urandom_range(0, 3));
      req(c, 16'($urandom()), p, n, nn);
    end
    cause = 2'b00;
    @(negedge clk);
    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule